// File: doc/BRIEF.md
# Synchronous HDLC Bit-Stream Deframer

This block takes a serial bit stream, one bit per cycle in which `bit_en` is high, and recovers HDLC frames from it. It counts runs of ones to recognise the flag pattern, removes the zeros a transmitter inserts after five ones, and packs the remaining data bits into bytes, least significant bit first. Finished bytes leave on a one-cycle `out_valid` strobe. Each byte carries an end-of-frame tag and an abort tag.

Bytes are held one deep, so the last byte of a frame can be tagged when the frame ends. A frame can end in four ways: a closing flag on a byte boundary, a run of seven ones, a flag that arrives off a byte boundary, or the clock-recovery-lost input (`dpll_lost`). The last three discard the partial byte and mark the last delivered byte as aborted. They also raise a sticky status bit, which software clears with a pulse. After an abort the block hunts for a new flag and ignores everything before it. A frame that closes cleanly but has fewer than `MIN_BYTES` bytes is also tagged as aborted.

Top module: `hdlc_deframer`

## Requirements
- R1: After reset `out_valid`, `sticky_abort` and `sticky_dpll` are 0 and the block is hunting for a flag.
- R2: A flag is a 0, exactly six 1s and a 0. While hunting, no bits produce output until such a flag has been received, and that flag opens a frame.
- R3: Inside a frame, a 0 that follows exactly five consecutive 1s is removed. The other bits are packed into bytes with the first received bit in bit 0.
- R4: When a flag ends on a byte boundary, all bytes of the frame are delivered in order. The last byte has `out_eof`=1, and `out_abort`=0 when the frame holds at least `MIN_BYTES` bytes. Back-to-back flags deliver nothing, and the frame stays open for the next bytes.
- R5: A cleanly closed frame with 1 to `MIN_BYTES`-1 bytes has its last byte tagged `out_eof`=1 and `out_abort`=1, and `sticky_abort` does not change.
- R6: A seventh consecutive 1 inside a frame aborts the frame. Every byte completed before that bit is delivered. The partial byte holding it is dropped. The last delivered byte has `out_eof`=1 and `out_abort`=1, and `sticky_abort` becomes 1.
- R7: A flag whose final 0 does not complete a byte aborts the frame. Every byte completed before that final 0 is delivered, including a byte that holds the start of the flag. The last delivered byte has `out_eof`=1 and `out_abort`=1, and `sticky_abort` becomes 1.
- R8: `dpll_lost` high in any cycle while a frame is open aborts it and delivers the completed bytes, the last with `out_eof`=1 and `out_abort`=1. It also sets `sticky_dpll` and ignores that cycle's bit. While hunting, `dpll_lost` has no effect.
- R9: After any abort the block hunts again, and no bytes are delivered until a new flag opens a frame.
- R10: A one-cycle pulse on `clr_abort` or `clr_dpll` clears the matching sticky bit. A set event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| dpll_lost | input | 1 | Clock recovery has lost lock |
| clr_abort | input | 1 | Clears `sticky_abort` |
| clr_dpll | input | 1 | Clears `sticky_dpll` |
| out_valid | output | 1 | Byte strobe, one cycle |
| out_data | output | 8 | Delivered byte |
| out_eof | output | 1 | Byte is the last of its frame |
| out_abort | output | 1 | Frame ended abnormally or was too short |
| sticky_abort | output | 1 | A seven-ones or misaligned-flag abort has occurred |
| sticky_dpll | output | 1 | A frame was lost to `dpll_lost` |

## Verification
The assertions assume that `dpll_lost` and the clear pulses are single-cycle events that are never driven together with a set event they would conflict with. They also assume that `bit_en` never holds two bits in one cycle. The bench keeps to this by driving at most one input event per cycle and by leaving an idle cycle between line bits. Frame bodies are built by a stuffing routine in the bench. Abort stimulus is inserted as raw, unstuffed bits, so that each abort occurs at a known bit position after the last whole byte.

// File: rtl/hdlc_deframer_pkg.sv
package hdlc_deframer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int RUN_W  = 3;

  typedef enum logic [1:0] {EV_DATA, EV_DROP, EV_FLAG, EV_RUN7} bit_ev_e;

  // Meaning of the incoming bit given the number of ones just before it.
  function automatic bit_ev_e classify(input logic [RUN_W-1:0] ones, input logic b);
    if (b)
      return (ones >= RUN_W'(6)) ? EV_RUN7 : EV_DATA;
    if (ones == RUN_W'(5))
      return EV_DROP;
    if (ones == RUN_W'(6))
      return EV_FLAG;
    return EV_DATA;
  endfunction

  function automatic logic [RUN_W-1:0] next_run(input logic [RUN_W-1:0] ones, input logic b);
    if (!b)
      return '0;
    return (ones == '1) ? ones : ones + RUN_W'(1);
  endfunction

  // Bits arrive LSB first: new bit enters at the top and moves down.
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sh, input logic b);
    return {b, sh[BYTE_W-1:1]};
  endfunction
endpackage

// File: rtl/hdlc_run_detect.sv
module hdlc_run_detect
  import hdlc_deframer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    bit_in,
  output bit_ev_e ev
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_q <= '0;
    else if (bit_en)
      run_q <= next_run(run_q, bit_in);
  end

  assign ev = classify(run_q, bit_in);
endmodule

// File: rtl/hdlc_byte_asm.sv
module hdlc_byte_asm
  import hdlc_deframer_pkg::*;
#(
  parameter int MIN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              dpll_lost,
  input  bit_ev_e           ev,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_eof,
  output logic              out_abort,
  output logic              in_frame,
  output logic              run7_evt,
  output logic              misalign_evt,
  output logic              dpll_evt,
  output logic              open_evt,
  output logic              close_evt
);
  localparam int NB_W = $clog2(MIN_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);
  localparam logic [NB_W-1:0]  NB_MIN   = NB_W'(MIN_BYTES);

  logic [BYTE_W-1:0] shreg, pend, nxt_byte;
  logic [CNT_W-1:0]  cnt;
  logic [NB_W-1:0]   nbytes;
  logic              pend_vld;
  logic              step, flag_hit, data_evt, abort_any, short_frame;

  assign dpll_evt     = in_frame && dpll_lost;
  assign step         = bit_en && !dpll_evt;
  assign flag_hit     = step && (ev == EV_FLAG);
  assign open_evt     = !in_frame && flag_hit;
  assign close_evt    = in_frame && flag_hit && (cnt == LAST_POS);
  assign misalign_evt = in_frame && flag_hit && (cnt != LAST_POS);
  assign run7_evt     = in_frame && step && (ev == EV_RUN7);
  assign data_evt     = in_frame && step && (ev == EV_DATA);
  assign abort_any    = run7_evt || misalign_evt || dpll_evt;
  assign short_frame  = nbytes < NB_MIN;
  assign nxt_byte     = shift_in(shreg, bit_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      shreg     <= '0;
      pend      <= '0;
      pend_vld  <= 1'b0;
      cnt       <= '0;
      nbytes    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
      if (abort_any) begin
        out_valid <= pend_vld;
        out_data  <= pend;
        out_eof   <= 1'b1;
        out_abort <= 1'b1;
        pend_vld  <= 1'b0;
        in_frame  <= 1'b0;
      end else if (close_evt) begin
        out_valid <= pend_vld;
        out_data  <= pend;
        out_eof   <= 1'b1;
        out_abort <= short_frame;
        pend_vld  <= 1'b0;
        cnt       <= '0;
        nbytes    <= '0;
      end else if (open_evt) begin
        in_frame  <= 1'b1;
        pend_vld  <= 1'b0;
        cnt       <= '0;
        nbytes    <= '0;
      end else if (data_evt) begin
        shreg <= nxt_byte;
        cnt   <= cnt + CNT_W'(1);
        if (cnt == LAST_POS) begin
          out_valid <= pend_vld;
          out_data  <= pend;
          pend      <= nxt_byte;
          pend_vld  <= 1'b1;
          if (nbytes != NB_MIN)
            nbytes <= nbytes + NB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_sticky.sv
module hdlc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= 1'b0;
    else if (set_i)
      q <= 1'b1;
    else if (clr_i)
      q <= 1'b0;
  end
endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_deframer_pkg::*;
#(
  parameter int MIN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              dpll_lost,
  input  logic              clr_abort,
  input  logic              clr_dpll,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_eof,
  output logic              out_abort,
  output logic              sticky_abort,
  output logic              sticky_dpll
);
  bit_ev_e ev;
  logic    in_frame, run7_evt, misalign_evt, dpll_evt, open_evt, close_evt;

  hdlc_run_detect u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .ev     (ev)
  );

  hdlc_byte_asm #(.MIN_BYTES(MIN_BYTES)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .bit_in       (bit_in),
    .dpll_lost    (dpll_lost),
    .ev           (ev),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_eof      (out_eof),
    .out_abort    (out_abort),
    .in_frame     (in_frame),
    .run7_evt     (run7_evt),
    .misalign_evt (misalign_evt),
    .dpll_evt     (dpll_evt),
    .open_evt     (open_evt),
    .close_evt    (close_evt)
  );

  hdlc_sticky u_abort_st (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (run7_evt || misalign_evt),
    .clr_i (clr_abort),
    .q     (sticky_abort)
  );

  hdlc_sticky u_dpll_st (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (dpll_evt),
    .clr_i (clr_dpll),
    .q     (sticky_dpll)
  );
endmodule

// File: rtl/hdlc_deframer_chk.sv
module hdlc_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_abort,
  input logic out_valid,
  input logic out_eof,
  input logic out_abort,
  input logic in_frame,
  input logic run7_evt,
  input logic misalign_evt,
  input logic dpll_evt,
  input logic open_evt,
  input logic close_evt,
  input logic sticky_abort,
  input logic sticky_dpll
);
  // R4
  abort_tag_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_abort |-> out_eof);

  // R9
  hunt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_frame));

  // R4
  mid_frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eof |-> in_frame);

  // R4
  close_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> in_frame);

  // R2
  open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> in_frame && !out_valid);

  // R6
  run7_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run7_evt |=> !in_frame && sticky_abort);

  // R7
  misalign_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |=> !in_frame && sticky_abort);

  // R8
  dpll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_evt |=> !in_frame && sticky_dpll);

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_abort && !run7_evt && !misalign_evt |=> !sticky_abort);
endmodule

bind hdlc_deframer hdlc_deframer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_abort    (clr_abort),
  .out_valid    (out_valid),
  .out_eof      (out_eof),
  .out_abort    (out_abort),
  .in_frame     (in_frame),
  .run7_evt     (run7_evt),
  .misalign_evt (misalign_evt),
  .dpll_evt     (dpll_evt),
  .open_evt     (open_evt),
  .close_evt    (close_evt),
  .sticky_abort (sticky_abort),
  .sticky_dpll  (sticky_dpll)
);

// File: tb/tb_hdlc_deframer.sv
module tb_hdlc_deframer;
  localparam int MINB = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, bit_in = 1'b0, dpll_lost = 1'b0;
  logic       clr_abort = 1'b0, clr_dpll = 1'b0;
  logic       out_valid, out_eof, out_abort, sticky_abort, sticky_dpll;
  logic [7:0] out_data;

  int errs = 0;
  int checks = 0;
  int run1 = 0;

  typedef struct packed {logic [7:0] d; logic e; logic a;} rec_t;
  rec_t act[$];
  rec_t exq[$];
  logic tx[$];

  always #5 clk = ~clk;

  hdlc_deframer #(.MIN_BYTES(MINB)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .dpll_lost(dpll_lost), .clr_abort(clr_abort), .clr_dpll(clr_dpll),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .out_abort(out_abort), .sticky_abort(sticky_abort), .sticky_dpll(sticky_dpll)
  );

  always @(negedge clk)
    if (rst_n && out_valid) act.push_back({out_data, out_eof, out_abort});

  task automatic check(string req, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, want);
    end
  endtask

  task automatic add_raw(logic b);
    tx.push_back(b);
    run1 = b ? run1 + 1 : 0;
  endtask

  task automatic add_data_bit(logic b);
    add_raw(b);
    if (b && run1 == 5) add_raw(1'b0);
  endtask

  task automatic add_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) add_data_bit(v[i]);
  endtask

  task automatic add_flag();
    add_raw(1'b0);
    for (int i = 0; i < 6; i++) add_raw(1'b1);
    add_raw(1'b0);
  endtask

  task automatic send_all();
    foreach (tx[i]) begin
      @(negedge clk); bit_en = 1'b1; bit_in = tx[i];
      @(negedge clk); bit_en = 1'b0;
    end
    tx.delete();
  endtask

  task automatic expect_rec(logic [7:0] d, logic e, logic a);
    exq.push_back({d, e, a});
  endtask

  // Tag the final expected record with end-of-frame and abort.
  task automatic tag_last_abort();
    if (exq.size() > 0) begin
      exq[exq.size()-1].e = 1'b1;
      exq[exq.size()-1].a = 1'b1;
    end
  endtask

  task automatic compare(string req);
    repeat (4) @(negedge clk);
    check({req, " record count"}, act.size(), exq.size());
    for (int i = 0; i < act.size() && i < exq.size(); i++)
      check({req, " record"}, act[i], exq[i]);
    act.delete();
    exq.delete();
  endtask

  task automatic pulse_clr_abort();
    @(negedge clk); clr_abort = 1'b1;
    @(negedge clk); clr_abort = 1'b0;
  endtask

  task automatic pulse_clr_dpll();
    @(negedge clk); clr_dpll = 1'b1;
    @(negedge clk); clr_dpll = 1'b0;
  endtask

  task automatic pulse_dpll();
    @(negedge clk); dpll_lost = 1'b1;
    @(negedge clk); dpll_lost = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 sticky_abort", sticky_abort, 0);
    check("R1 sticky_dpll", sticky_dpll, 0);

    // R2 hunting: bytes before any flag are ignored; R4 empty frames
    add_byte(8'h55); add_byte(8'h33); add_byte(8'h0F);
    send_all();
    compare("R2 hunt");
    add_flag(); add_flag(); add_flag();
    send_all();
    compare("R4 empty frames");

    // R3/R4 sweep of every byte value in two-byte frames
    for (int v = 0; v < 256; v++) begin
      add_flag(); add_byte(8'(v)); add_byte(8'(v) ^ 8'hA5); add_flag();
      expect_rec(8'(v), 0, 0);
      expect_rec(8'(v) ^ 8'hA5, 1, 0);
      send_all();
      compare("R3 R4 sweep");
    end

    // R3 stuffing-heavy frames of several lengths
    for (int n = 2; n <= 5; n++) begin
      add_flag();
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = (i % 3 == 0) ? 8'hFF : (i % 3 == 1) ? 8'h7E : 8'h3E;
        add_byte(b);
        expect_rec(b, i == n - 1, 0);
      end
      add_flag();
      send_all();
      compare("R3 stuffed frame");
    end

    // R5 short frames
    for (int v = 0; v < 256; v += 37) begin
      add_flag(); add_byte(8'(v)); add_flag();
      expect_rec(8'(v), 1, 1);
      send_all();
      compare("R5 short frame");
    end
    check("R5 sticky_abort untouched", sticky_abort, 0);

    // R6 seven ones after k bytes and j zero bits; R9 hunt afterwards
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 8; j++) begin
        add_flag();
        for (int i = 0; i < k; i++) begin
          add_byte(8'h10 + 8'(i));
          expect_rec(8'h10 + 8'(i), 0, 0);
        end
        for (int i = 0; i < j; i++) add_raw(1'b0);
        for (int i = 0; i < 7; i++) add_raw(1'b1);
        if (j >= 2) expect_rec(8'(8'hFF << j), 0, 0);
        tag_last_abort();
        add_byte(8'h55); add_byte(8'h0F);
        send_all();
        compare("R6 seven ones / R9 hunt");
        check("R6 sticky_abort", sticky_abort, 1);
        pulse_clr_abort();
        check("R10 clear abort", sticky_abort, 0);
      end
    end

    // R7 misaligned flag after k bytes and j zero bits
    for (int k = 0; k < 4; k++) begin
      for (int j = 1; j < 8; j++) begin
        logic [7:0] xb;
        add_flag();
        for (int i = 0; i < k; i++) begin
          add_byte(8'h21 + 8'(i));
          expect_rec(8'h21 + 8'(i), 0, 0);
        end
        for (int i = 0; i < j; i++) add_raw(1'b0);
        add_flag();
        xb = 8'hFF << (j + 1);
        expect_rec(xb, 0, 0);
        tag_last_abort();
        add_byte(8'h33);
        send_all();
        compare("R7 misaligned flag / R9 hunt");
        check("R7 sticky_abort", sticky_abort, 1);
        pulse_clr_abort();
        check("R10 clear abort", sticky_abort, 0);
      end
    end

    // R8 clock-recovery loss mid-frame
    for (int k = 1; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        add_flag();
        for (int i = 0; i < k; i++) begin
          add_byte(8'h40 + 8'(i));
          expect_rec(8'h40 + 8'(i), 0, 0);
        end
        for (int i = 0; i < j; i++) add_raw(1'b0);
        send_all();
        pulse_dpll();
        tag_last_abort();
        add_byte(8'h12);
        send_all();
        compare("R8 dpll abort / R9 hunt");
        check("R8 sticky_dpll", sticky_dpll, 1);
        check("R8 sticky_abort stays", sticky_abort, 0);
        pulse_clr_dpll();
        check("R10 clear dpll", sticky_dpll, 0);
      end
    end

    // R8 no effect while hunting
    pulse_dpll();
    repeat (2) @(negedge clk);
    check("R8 hunt dpll ignored", sticky_dpll, 0);
    add_flag(); add_byte(8'hC3); add_byte(8'h3C); add_flag();
    expect_rec(8'hC3, 0, 0);
    expect_rec(8'h3C, 1, 0);
    send_all();
    compare("R8 recovery frame");

    finish_run();
  end
endmodule